// File: doc/BRIEF.md
# Sequential Wide Unsigned Adder

This block adds two unsigned 256-bit operands. It uses one 32-bit adder and runs it over eight clock cycles instead of building a single 256-bit carry chain. A start strobe captures both operands. The block then works through the 32-bit slices from the least significant slice to the most significant, one slice per cycle. A carry register passes the carry from each slice to the next. The carry is the extra (33rd) bit of the slice sum, used as it is, without inversion.

When the last slice has been written, the block raises a one-cycle done pulse. The 256-bit sum and the final carry-out then stay valid until the next accepted start. While busy is high the block ignores any new start, so only one operation is ever in progress. The longest combinational path is one 32-bit add plus its carry-in.

Top module: `seq_wide_adder`

## Requirements
- R1: When done is high, sum equals (opA + opB) mod 2^256 for the operands captured at the accepted start.
- R2: When done is high, carryOut equals bit 256 of the full 257-bit sum opA + opB.
- R3: Slices are added from the least significant (bits 31:0) upward. The carry out of each slice is added into the next slice, so a carry born in any slice reaches all higher slices. For example, all-ones plus one gives sum 0 and carryOut 1.
- R4: A start that is high at a clock edge while busy is low is accepted. Busy is high from the next cycle on, for exactly 8 cycles.
- R5: Done is a single-cycle pulse. It appears in the cycle after the eighth slice is written, which is the ninth cycle after the accepting edge, and busy is low in that cycle.
- R6: An accepted start clears the carry register, so the carry-out of an earlier operation does not enter the first slice of the new one.
- R7: A start that is high while busy is high is ignored. The operands presented with it are not captured, and the running result is unchanged.
- R8: After done, sum and carryOut hold their values until the next accepted start.
- R9: A synchronous active-high reset brings the block to idle with busy low, done low and carryOut low. A reset during an operation aborts that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an addition; taken only while idle |
| opA | input | 256 | First unsigned operand, captured on an accepted start |
| opB | input | 256 | Second unsigned operand, captured on an accepted start |
| busy | output | 1 | High while slices are being added |
| done | output | 1 | One-cycle pulse when the result is complete |
| sum | output | 256 | Result, valid from done until the next accepted start |
| carryOut | output | 1 | Carry out of the most significant slice |

## Verification
A slice counter that is off by one moves done one cycle early or late at the ports. It also leaves one slice of sum unwritten or shifted out of place, so the next done pulse already shows it. A carry register that is not cleared, or that is inverted, shows as a wrong low slice or a wrong carryOut on the first operation after one that ended with carry 1. A carry that is not passed between slices shows only when a carry crosses a slice boundary. The walking-boundary patterns expose such a fault within one operation, which is nine cycles.

// File: rtl/mpadd_pkg.sv
package mpadd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_e;

  // strobes sent from control to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear carry
    logic step;   // add one slice and shift
  } addStrobes_t;

endpackage

// File: rtl/mpadd_slice_adder.sv
module mpadd_slice_adder #(
  parameter int SLICE_WIDTH = 32
) (
  input  logic [SLICE_WIDTH-1:0] aIn,
  input  logic [SLICE_WIDTH-1:0] bIn,
  input  logic                   cIn,
  output logic [SLICE_WIDTH-1:0] sumOut,
  output logic                   cOut
);

  logic [SLICE_WIDTH:0] fullSum;

  always_comb begin
    fullSum = {1'b0, aIn} + {1'b0, bIn} + {{SLICE_WIDTH{1'b0}}, cIn};
    sumOut  = fullSum[SLICE_WIDTH-1:0];
    cOut    = fullSum[SLICE_WIDTH];   // the extra sum bit is the carry, as is
  end

endmodule

// File: rtl/mpadd_ctrl.sv
module mpadd_ctrl
  import mpadd_pkg::*;
#(
  parameter int NUM_SLICES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output addStrobes_t strobes
);

  localparam int CNT_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SLICES - 1);

  ctrlState_e       stateQ;
  logic [CNT_W-1:0] sliceIdxQ;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_IDLE;
      sliceIdxQ <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ    <= ST_RUN;
            sliceIdxQ <= '0;
          end
        end
        ST_RUN: begin
          sliceIdxQ <= sliceIdxQ + 1'b1;
          if (sliceIdxQ == LAST_IDX) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load = (stateQ == ST_IDLE) && start;
    strobes.step = (stateQ == ST_RUN);
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;

  // ---------------- assertions ----------------
  logic [CNT_W:0] runLenQ;   // busy cycles since the last load

  always_ff @(posedge clk) begin
    if (rst)               runLenQ <= '0;
    else if (strobes.load) runLenQ <= '0;
    else if (busy)         runLenQ <= runLenQ + 1'b1;
  end

  assert_start_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_run_length_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (runLenQ == (CNT_W+1)'(NUM_SLICES)));

endmodule

// File: rtl/mpadd_datapath.sv
module mpadd_datapath
  import mpadd_pkg::*;
#(
  parameter int OP_WIDTH    = 256,
  parameter int SLICE_WIDTH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  addStrobes_t         strobes,
  input  logic [OP_WIDTH-1:0] opA,
  input  logic [OP_WIDTH-1:0] opB,
  output logic [OP_WIDTH-1:0] sum,
  output logic                carryOut
);

  localparam int SW = SLICE_WIDTH;

  logic [OP_WIDTH-1:0] opAQ, opBQ, sumQ;
  logic                carryQ;
  logic [SW-1:0]       sliceSum;
  logic                sliceCarry;

  mpadd_slice_adder #(.SLICE_WIDTH(SW)) u_slice (
    .aIn    (opAQ[SW-1:0]),
    .bIn    (opBQ[SW-1:0]),
    .cIn    (carryQ),
    .sumOut (sliceSum),
    .cOut   (sliceCarry)
  );

  // operands shift down one slice per step; results enter from the top,
  // so after the last step every slice sits at its own position
  always_ff @(posedge clk) begin
    if (strobes.load) begin
      opAQ <= opA;
      opBQ <= opB;
    end else if (strobes.step) begin
      opAQ <= {{SW{1'b0}}, opAQ[OP_WIDTH-1:SW]};
      opBQ <= {{SW{1'b0}}, opBQ[OP_WIDTH-1:SW]};
      sumQ <= {sliceSum, sumQ[OP_WIDTH-1:SW]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               carryQ <= 1'b0;
    else if (strobes.load) carryQ <= 1'b0;
    else if (strobes.step) carryQ <= sliceCarry;
  end

  assign sum      = sumQ;
  assign carryOut = carryQ;

  // ---------------- assertions ----------------
  assert_carry_clear_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (carryQ == 1'b0));

  assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.step |-> !strobes.load);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.step) |=> ($stable(sumQ) && $stable(carryQ)));

endmodule

// File: rtl/seq_wide_adder.sv
module seq_wide_adder
  import mpadd_pkg::*;
#(
  parameter int OP_WIDTH    = 256,
  parameter int SLICE_WIDTH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [OP_WIDTH-1:0] opA,
  input  logic [OP_WIDTH-1:0] opB,
  output logic                busy,
  output logic                done,
  output logic [OP_WIDTH-1:0] sum,
  output logic                carryOut
);

  localparam int NUM_SLICES = OP_WIDTH / SLICE_WIDTH;

  addStrobes_t strobes;

  mpadd_ctrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .strobes (strobes)
  );

  mpadd_datapath #(
    .OP_WIDTH    (OP_WIDTH),
    .SLICE_WIDTH (SLICE_WIDTH)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .sum      (sum),
    .carryOut (carryOut)
  );

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && !carryOut));

endmodule

// File: tb/tb_seq_wide_adder.sv
`timescale 1ns/1ps
module tb_seq_wide_adder;

  localparam int W  = 256;
  localparam int SW = 32;
  localparam int NS = W / SW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy, done, carryOut;
  logic [W-1:0] sum;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;   // 125 MHz

  seq_wide_adder #(.OP_WIDTH(W), .SLICE_WIDTH(SW)) dut (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .sum(sum), .carryOut(carryOut)
  );

  task automatic check(input logic ok, input string req,
                       input logic [W:0] act, input logic [W:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] randWide();
    logic [W-1:0] v;
    for (int i = 0; i < NS; i++) v[i*SW +: SW] = $urandom;
    return v;
  endfunction

  // full operation with cycle-exact protocol checks; optional ignored start
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic injectBusyStart);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);                          // accepting edge passed
    start = 1'b0;
    check(busy === 1'b1, "R4 busy after start", {256'b0, busy}, 257'd1);
    for (int k = 1; k < NS; k++) begin
      if (injectBusyStart && k == 3) begin
        opA = ~a; opB = ~b; start = 1'b1;
      end else begin
        start = 1'b0;
        opA = randWide(); opB = randWide();   // R7: no effect after capture
      end
      @(negedge clk);
      check(busy === 1'b1 && done === 1'b0, "R4 busy held, done low",
            {255'b0, busy, done}, 257'd2);
    end
    start = 1'b0;
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R5 done pulse timing",
          {255'b0, busy, done}, 257'd1);
    check(sum === exp[W-1:0], injectBusyStart ? "R7 sum with ignored start" : "R1 sum",
          {1'b0, sum}, {1'b0, exp[W-1:0]});
    check(carryOut === exp[W], "R2 carryOut", {256'b0, carryOut}, {256'b0, exp[W]});
    @(negedge clk);
    check(done === 1'b0, "R5 done single cycle", {256'b0, done}, 257'd0);
    check(sum === exp[W-1:0] && carryOut === exp[W], "R8 result hold",
          {carryOut, sum}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL R4 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [W-1:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && done === 1'b0 && carryOut === 1'b0, "R9 reset state",
          {254'b0, busy, done, carryOut}, 257'd0);

    runOp('0, '0, 1'b0);
    runOp(ones, {{(W-1){1'b0}}, 1'b1}, 1'b0);      // R3 full ripple
    runOp(ones, ones, 1'b0);
    // R6: previous carryOut was 1; a carry must not leak into slice 0
    runOp({{(W-1){1'b0}}, 1'b1}, {{(W-1){1'b0}}, 1'b1}, 1'b0);
    // R3 walking boundary carries, each slice in turn
    for (int k = 0; k < NS; k++) begin
      logic [W-1:0] a, b;
      a = '0; b = '0;
      a[k*SW +: SW] = '1;
      b[k*SW] = 1'b1;
      runOp(a, b, 1'b0);
    end
    // R7 start during busy ignored
    runOp(randWide(), randWide(), 1'b1);
    runOp(ones, ones, 1'b1);
    // arithmetic sweep
    for (int n = 0; n < 150; n++) runOp(randWide(), randWide(), 1'b0);

    // R9 reset mid-operation
    @(negedge clk);
    opA = ones; opB = ones; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && done === 1'b0 && carryOut === 1'b0, "R9 reset aborts op",
          {254'b0, busy, done, carryOut}, 257'd0);
    repeat (NS + 2) @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9 no done after abort",
          {255'b0, busy, done}, 257'd0);
    runOp(randWide(), randWide(), 1'b0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule